// File: doc/BRIEF.md
# Serial Receive Character Assembler with Parity Check

This block collects a serial bit stream, one bit per cycle in which a bit strobe is high, and groups the bits into characters of five to eight data bits. Parity can be added as one extra bit per character. Each finished character appears as an 8-bit word with a one-cycle valid strobe. The first received bit sits at bit 0 of the word.

The word is a snapshot of the receive shift window and is not zero-filled. When a parity bit fits inside the word, it sits directly above the data. The remaining upper positions hold the stream bits that arrived just before the character.

Parity is checked for either even or odd sense. A failure sets a sticky status flag, which stays set until an error-clear command. When enabled, the flag also drives an interrupt request for a special receive condition. Character storage and other receive error sources belong to the surrounding receiver.

Top module: `rx_char_asm`

## Requirements
- R1: `cfg_len` selects the data bits per character: 0 selects 5, 1 selects 6, 2 selects 7 and 3 selects 8. A character completes on the N-th strobed bit, or on the (N+1)-th when `par_en` is 1. No valid strobe occurs before that bit.
- R2: Bits arrive least significant first. Data bit k of a character appears at `rx_word[k]`.
- R3: With `par_en` = 1 and N < 8, the received parity bit appears at `rx_word[N]`. With N = 8, the word holds the eight data bits only.
- R4: Let W be N, plus 1 when parity is on, limited to 8. Word positions W..7 hold the 8−W stream bits received immediately before the character, in arrival order, with the earliest at position W. Bits from before the last reset count as 0.
- R5: `rx_valid` is high for exactly one cycle per character. It is high in the cycle after the clock edge that samples the final bit, and `rx_word` is valid in that same cycle.
- R6: With `par_even` = 1, a character fails when the count of ones over its data and parity bits is odd. With `par_even` = 0, it fails when that count is even. With `par_en` = 0, no character fails.
- R7: `par_err` rises in the cycle after the `rx_valid` cycle of a failing character. It stays high through later good characters.
- R8: `err_clr` high for one cycle clears `par_err` at the next edge. If a new failure is reported in that same cycle, `par_err` stays set.
- R9: `irq` is high exactly when `par_err` is high and `irq_en` was high in the previous cycle.
- R10: `bit_in` is ignored in cycles where `bit_stb` is low.
- R11: Synchronous `rst` clears all outputs and the window, and restarts character counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit |
| bit_stb | input | 1 | Marks `bit_in` as a valid received bit |
| cfg_len | input | 2 | Data bits per character code (0..3 for 5..8) |
| par_en | input | 1 | Adds and checks a parity bit |
| par_even | input | 1 | 1 selects even parity, 0 selects odd parity |
| irq_en | input | 1 | Allows the parity flag to raise `irq` |
| err_clr | input | 1 | Clears the sticky parity flag |
| rx_word | output | 8 | Assembled character word |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_word` |
| par_err | output | 1 | Sticky parity failure flag |
| irq | output | 1 | Special receive condition request |

## Verification
A bit counter that is off by one moves every later character. The fault shows on the very next `rx_valid`, either as a strobe one bit early or late or as a word shifted by a position. A wrong staging choice or window rotation leaves the low bits right but corrupts the parity position or the upper snapshot bits. A running parity accumulator that is not restarted at a character boundary flips `par_err` on the following character, one cycle after its strobe. An error flag with the wrong clear priority shows one cycle after a collision between `err_clr` and a failing character.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

  typedef enum logic [1:0] {
    LEN_CODE_5 = 2'd0,
    LEN_CODE_6 = 2'd1,
    LEN_CODE_7 = 2'd2,
    LEN_CODE_8 = 2'd3
  } len_code_e;

  // Source index in the window for output position i after rotating by s.
  function automatic int wrap_idx(input int i, input int s, input int w);
    return (i + s) % w;
  endfunction

endpackage

// File: rtl/rxa_shift.sv
module rxa_shift #(
  parameter int W     = 8,
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             bit_stb,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             par_en,
  input  logic             par_even,
  output logic [W-1:0]     rx_word,
  output logic             rx_valid,
  output logic             fail
);
  import rxa_pkg::*;

  localparam int CW   = $clog2(W + 2);
  localparam int IW   = $clog2(W);
  localparam int BASE = W - (2 ** LEN_W) + 1;

  logic [W-1:0]  win_q, win_nx, stage_q, rot;
  logic [CW-1:0] cnt_q, n_data, n_total, n_word;
  logic          acc_q, acc_nx, at_word, at_end;

  always_comb begin
    n_data  = CW'(BASE) + CW'(cfg_len);
    n_total = n_data + CW'(par_en);
    n_word  = (n_total > CW'(W)) ? CW'(W) : n_total;
    win_nx  = {bit_in, win_q[W-1:1]};
    acc_nx  = acc_q ^ bit_in;
    at_word = bit_stb && (cnt_q == n_word - CW'(1));
    at_end  = bit_stb && (cnt_q == n_total - CW'(1));
    for (int i = 0; i < W; i++) begin
      int j;
      j = wrap_idx(i, W - int'(n_word), W);
      rot[i] = win_nx[j[IW-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q    <= '0;
      stage_q  <= '0;
      cnt_q    <= '0;
      acc_q    <= 1'b0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
      fail     <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      fail     <= 1'b0;
      if (bit_stb) begin
        win_q <= win_nx;
        if (at_word) stage_q <= rot;
        if (at_end) begin
          cnt_q    <= '0;
          acc_q    <= 1'b0;
          rx_valid <= 1'b1;
          rx_word  <= (n_word == n_total) ? rot : stage_q;
          fail     <= par_en && (acc_nx == par_even);
        end else begin
          cnt_q <= cnt_q + CW'(1);
          acc_q <= acc_nx;
        end
      end
    end
  end

endmodule

// File: rtl/rxa_errflag.sv
module rxa_errflag (
  input  logic clk,
  input  logic rst,
  input  logic fail,
  input  logic err_clr,
  input  logic irq_en,
  output logic par_err,
  output logic irq
);
  logic flag_nx;

  always_comb flag_nx = (par_err && !err_clr) || fail;

  always_ff @(posedge clk) begin
    if (rst) begin
      par_err <= 1'b0;
      irq     <= 1'b0;
    end else begin
      par_err <= flag_nx;
      irq     <= flag_nx && irq_en;
    end
  end

endmodule

// File: rtl/rx_char_asm.sv
module rx_char_asm #(
  parameter int W     = 8,
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             bit_stb,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             par_en,
  input  logic             par_even,
  input  logic             irq_en,
  input  logic             err_clr,
  output logic [W-1:0]     rx_word,
  output logic             rx_valid,
  output logic             par_err,
  output logic             irq
);
  logic fail_q;

  rxa_shift #(.W(W), .LEN_W(LEN_W)) i_shift (
    .clk      (clk),
    .rst      (rst),
    .bit_in   (bit_in),
    .bit_stb  (bit_stb),
    .cfg_len  (cfg_len),
    .par_en   (par_en),
    .par_even (par_even),
    .rx_word  (rx_word),
    .rx_valid (rx_valid),
    .fail     (fail_q)
  );

  rxa_errflag i_flag (
    .clk     (clk),
    .rst     (rst),
    .fail    (fail_q),
    .err_clr (err_clr),
    .irq_en  (irq_en),
    .par_err (par_err),
    .irq     (irq)
  );

endmodule

// File: rtl/rxa_chk.sv
module rxa_chk (
  input logic clk,
  input logic rst,
  input logic bit_stb,
  input logic rx_valid,
  input logic fail,
  input logic err_clr,
  input logic irq_en,
  input logic par_err,
  input logic irq
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst) rx_valid |=> !rx_valid); // R5
  AST_VALID_NEEDS_STB: assert property (@(posedge clk) disable iff (rst) rx_valid |-> $past(bit_stb)); // R10
  AST_FAIL_WITH_VALID: assert property (@(posedge clk) disable iff (rst) fail |-> rx_valid); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) (par_err && !err_clr) |=> par_err); // R7
  AST_ERR_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(par_err) |-> $past(fail)); // R7
  AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (rst) (err_clr && !fail) |=> !par_err); // R8
  AST_CLR_COLLIDE: assert property (@(posedge clk) disable iff (rst) fail |=> par_err); // R8
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst) irq |-> par_err); // R9
  AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (rst) irq == (par_err && $past(irq_en))); // R9
endmodule

bind rx_char_asm rxa_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .bit_stb  (bit_stb),
  .rx_valid (rx_valid),
  .fail     (fail_q),
  .err_clr  (err_clr),
  .irq_en   (irq_en),
  .par_err  (par_err),
  .irq      (irq)
);

// File: tb/test_rx_char_asm.sv
module test_rx_char_asm;
  logic       clk = 1'b0, rst = 1'b1, bit_in = 1'b0, bit_stb = 1'b0;
  logic       par_en = 1'b0, par_even = 1'b0, irq_en = 1'b0, err_clr = 1'b0;
  logic [1:0] cfg_len = 2'd0;
  logic [7:0] rx_word;
  logic       rx_valid, par_err, irq;

  int n_chk = 0, n_bad = 0;
  bit hist [0:4095];
  int hcnt = 0, hstart = 0;
  bit exp_err = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_char_asm i_rx_char_asm (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_stb(bit_stb), .cfg_len(cfg_len),
    .par_en(par_en), .par_even(par_even), .irq_en(irq_en), .err_clr(err_clr),
    .rx_word(rx_word), .rx_valid(rx_valid), .par_err(par_err), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_word(input int t);
    int first = hcnt - t;
    int w = (t > 8) ? 8 : t;
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      int k = (i < w) ? first + i : first - (8 - w) + (i - w);
      r[i] = (k >= hstart) ? hist[k] : 1'b0;
    end
    return r;
  endfunction

  task automatic send_bit(input bit b);
    @(negedge clk);
    bit_in = b; bit_stb = 1'b1;
    hist[hcnt] = b; hcnt++;
    @(negedge clk);
    bit_stb = 1'b0; bit_in = ~b;
  endtask

  task automatic send_char(input logic [7:0] data, input int nb, input bit pe, input bit ev,
                           input bit bad, input bit clr_at_valid, input string tag);
    bit x = 1'b0;
    bit p;
    int t = nb + (pe ? 1 : 0);
    logic [7:0] ew;
    cfg_len = 2'(nb - 5); par_en = pe; par_even = ev;
    for (int i = 0; i < nb; i++) begin
      send_bit(data[i]);
      x ^= data[i];
      if (i < t - 1) chk(rx_valid == 1'b0, {tag, " R1 early valid"}, rx_valid, 0);
    end
    p = ev ? x : ~x;
    if (bad) p = ~p;
    if (pe) send_bit(p);
    ew = exp_word(t);
    chk(rx_valid == 1'b1, {tag, " R5 valid"}, rx_valid, 1);
    chk(rx_word == ew, {tag, " word"}, rx_word, ew);
    if (clr_at_valid) err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(rx_valid == 1'b0, {tag, " R5 one cycle"}, rx_valid, 0);
    if (clr_at_valid) exp_err = pe && bad;
    else exp_err = exp_err || (pe && bad);
    chk(par_err == exp_err, {tag, " R6 R7 par_err"}, par_err, exp_err);
    chk(irq == (exp_err && irq_en), {tag, " R9 irq"}, irq, exp_err && irq_en);
  endtask

  task automatic clear_flag();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    exp_err = 1'b0;
    chk(par_err == 1'b0, "R8 clear", par_err, 0);
    chk(irq == 1'b0, "R9 irq after clear", irq, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rx_word == 8'h00, "R11 reset word", rx_word, 0);
    chk(rx_valid == 1'b0, "R11 reset valid", rx_valid, 0);
    chk(par_err == 1'b0, "R11 reset par_err", par_err, 0);
    chk(irq == 1'b0, "R11 reset irq", irq, 0);
  endtask

  task automatic t_lengths();
    send_char(8'hA5, 8, 0, 0, 0, 0, "R1 R2 len8");
    send_char(8'h16, 5, 0, 0, 0, 0, "R1 R2 R4 len5");
    send_char(8'h2B, 6, 0, 0, 0, 0, "R1 R2 R4 len6");
    send_char(8'h4E, 7, 0, 0, 0, 0, "R1 R2 R4 len7");
    send_char(8'hC3, 8, 0, 0, 0, 0, "R1 R2 len8b");
  endtask

  task automatic t_parity_in_word();
    send_char(8'h15, 5, 1, 1, 0, 0, "R3 R4 par5 even");
    chk(rx_word[5] == 1'b1, "R3 parity bit position 5", rx_word[5], 1);
    send_char(8'h21, 6, 1, 0, 0, 0, "R3 R4 par6 odd");
    chk(rx_word[6] == 1'b1, "R3 parity bit position 6", rx_word[6], 1);
    send_char(8'h7F, 7, 1, 1, 0, 0, "R3 par7 even");
    chk(rx_word[7] == 1'b1, "R3 parity bit position 7", rx_word[7], 1);
  endtask

  task automatic t_parity_sense();
    send_char(8'h81, 8, 1, 1, 0, 0, "R6 R3 par8 even good");
    chk(rx_word == 8'h81, "R3 par8 data only", rx_word, 8'h81);
    send_char(8'h81, 8, 1, 1, 1, 0, "R6 par8 even bad");
    clear_flag();
    send_char(8'h07, 5, 1, 0, 0, 0, "R6 odd good");
    send_char(8'h07, 5, 1, 0, 1, 0, "R6 odd bad");
    clear_flag();
    send_char(8'h0F, 6, 0, 1, 1, 0, "R6 disabled");
  endtask

  task automatic t_sticky();
    send_char(8'h33, 7, 1, 1, 1, 0, "R7 fail");
    send_char(8'h33, 7, 1, 1, 0, 0, "R7 good keeps flag");
    repeat (4) @(negedge clk);
    chk(par_err == 1'b1, "R7 idle keeps flag", par_err, 1);
    clear_flag();
  endtask

  task automatic t_collide();
    send_char(8'h55, 8, 1, 0, 1, 1, "R8 clear collides with fail");
    send_char(8'h55, 8, 1, 0, 0, 1, "R8 clear with good char");
  endtask

  task automatic t_irq();
    irq_en = 1'b1;
    send_char(8'h12, 5, 1, 1, 1, 0, "R9 irq on");
    @(negedge clk); irq_en = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R9 irq masked", irq, 0);
    chk(par_err == 1'b1, "R9 flag kept while masked", par_err, 1);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R9 irq unmasked", irq, 1);
    clear_flag();
    irq_en = 1'b0;
  endtask

  task automatic t_ignore();
    cfg_len = 2'd1; par_en = 1'b0;
    send_bit(1'b1);
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      bit_in = i[0];
      chk(rx_valid == 1'b0, "R10 no valid while idle", rx_valid, 0);
    end
    for (int i = 0; i < 4; i++) send_bit(i[1]);
    begin
      logic [7:0] ew = exp_word(6);
      chk(rx_valid == 1'b1, "R10 char completes", rx_valid, 1);
      chk(rx_word == ew, "R10 idle bits ignored", rx_word, ew);
    end
    @(negedge clk);
  endtask

  task automatic t_reset_mid();
    cfg_len = 2'd0; par_en = 1'b0;
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    hstart = hcnt;
    exp_err = 1'b0;
    chk(rx_word == 8'h00, "R11 mid reset word", rx_word, 0);
    send_char(8'h19, 5, 0, 0, 0, 0, "R11 R4 restart count");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R5: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lengths();
    t_parity_in_word();
    t_parity_sense();
    t_sticky();
    t_collide();
    t_irq();
    t_ignore();
    t_reset_mid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule